// File: doc/BRIEF.md
# CAN Transmit Mailbox Status Tracker

This block follows three CAN transmit mailboxes through their life cycle and presents their condition as flags plus one packed, read-only status byte. Software raises a transmit request or an abort for a mailbox through single-cycle strobes. The bit-level transmitter reports when a frame in a given mailbox has finished, and whether it went out successfully. Software acknowledges a finished request by strobing a clear for that mailbox.

Each mailbox is a two-state machine. The states are `SLOT_EMPTY` and `SLOT_PENDING`. The named transitions are `EV_ACCEPT` (a request arrives at an empty mailbox), `EV_FINISH` (the transmitter reports completion for a pending mailbox) and `EV_CANCEL` (an abort arrives at a pending mailbox). `EV_NONE` keeps the current state.

A priority unit looks at the pending set and the per-mailbox identifier keys on every cycle. It registers one flag that marks the pending mailbox with the lowest priority. It also drives a 2-bit code that names the next free mailbox, or the lowest-priority mailbox when all three are busy.

Top module: `can_txmb_tracker`

## Requirements
- R1: After reset every mailbox is empty, all completion, success and lowest-priority flags are 0, the code is 0, and the status byte reads 8'h1C.
- R2: A request strobe to an empty mailbox makes it pending at the next clock edge, so its empty flag goes to 0. A request strobe to a pending mailbox changes none of its flags.
- R3: A completion report for a pending mailbox sets that mailbox's empty flag and request-completed flag at the next edge. The transmit-OK flag takes the value 1 if the report signals success and 0 if it signals failure. A completion report for an empty mailbox is ignored.
- R4: An abort strobe to a pending mailbox makes it empty, sets its request-completed flag and clears its transmit-OK flag at the next edge. An abort strobe to an empty mailbox has no effect.
- R5: A clear strobe resets the mailbox's request-completed and transmit-OK flags at the next edge. When a completion for that mailbox arrives in the same cycle, the completion wins and both flags reflect the completion.
- R6: A mailbox accepts only one event per cycle, in the order completion, then abort, then request. A request together with an abort on an empty mailbox is taken as a request.
- R7: The lowest-priority flags are registered from the pending set of the previous cycle. A flag is 1 only for the one pending mailbox that has the numerically largest key, and only while at least two mailboxes are pending. When keys are equal, the higher index has the lower priority. At most one flag is 1.
- R8: In the cycle after a request strobe or a clear strobe for a mailbox, that mailbox's lowest-priority flag reads 0, whatever the pending set is.
- R9: While at least one mailbox is empty, the code is the lowest index among the empty mailboxes. The code follows the current state with no extra register.
- R10: While all three mailboxes are pending, the code is the index of the lowest-priority mailbox under the rule of R7, evaluated on the current keys.
- R11: The status byte is arranged, from bit 7 down to bit 0, as: lowest-priority flags for mailboxes 2, 1, 0, then empty flags for mailboxes 2, 1, 0, then the 2-bit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_req | input | 3 | Per-mailbox transmit request strobe |
| tx_abort | input | 3 | Per-mailbox abort strobe |
| done_valid | input | 1 | Transmitter reports a finished frame |
| done_idx | input | 2 | Mailbox index of the finished frame |
| done_ok | input | 1 | 1 = frame sent successfully, 0 = failed |
| rqcp_clr | input | 3 | Per-mailbox clear strobe for the completion flags |
| prio_key | input | 33 | Identifier keys, 11 bits per mailbox, mailbox 0 in the low bits |
| mb_empty | output | 3 | Mailbox has no pending request |
| req_done | output | 3 | Last request of the mailbox has finished |
| tx_ok | output | 3 | Last finished request was a successful transmit |
| low_flag | output | 3 | Mailbox is the lowest-priority pending one |
| mb_code | output | 2 | Next free mailbox, or lowest-priority mailbox when all are busy |
| status_byte | output | 8 | Packed low flags, empty flags and code |

## Verification
Two kinds of collision need checking. A transmitter completion can land in the same cycle as a software clear of that mailbox's completion flags. It can also land in the same cycle as an abort for that mailbox. The bench creates each case by driving both strobes together onto a pending mailbox. It then judges the result at the next edge: the completion must win, so the completion flag stays set and the success flag matches the reported outcome. A third case pairs a request strobe or a clear strobe with the priority scan, and the bench checks that the lowest-priority flag drops for exactly one cycle and then returns.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

    localparam int MB_COUNT = 3;
    localparam int KEY_W    = 11;

    typedef enum logic {
        SLOT_EMPTY   = 1'b0,
        SLOT_PENDING = 1'b1
    } slot_state_e;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_ACCEPT = 2'd1,
        EV_FINISH = 2'd2,
        EV_CANCEL = 2'd3
    } slot_evt_e;

endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
    import can_txmb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic abort_i,
    input  logic fin_i,
    input  logic fin_ok_i,
    input  logic clr_i,
    output logic empty_o,
    output logic done_o,
    output logic ok_o
);

    slot_state_e state_q, state_d;
    slot_evt_e   evt;
    logic        done_q, ok_q;

    // event selection: completion, then abort, then request (one per cycle)
    always_comb begin
        evt = EV_NONE;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (req_i) evt = EV_ACCEPT;
            end
            SLOT_PENDING: begin
                if (fin_i)        evt = EV_FINISH;
                else if (abort_i) evt = EV_CANCEL;
            end
            default: evt = EV_NONE;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (evt)
            EV_ACCEPT: state_d = SLOT_PENDING;
            EV_FINISH: state_d = SLOT_EMPTY;
            EV_CANCEL: state_d = SLOT_EMPTY;
            default:   state_d = state_q;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // completion flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ok_q   <= 1'b0;
        end else begin
            unique case (evt)
                EV_FINISH: begin
                    done_q <= 1'b1;
                    ok_q   <= fin_ok_i;
                end
                EV_CANCEL: begin
                    done_q <= 1'b1;
                    ok_q   <= 1'b0;
                end
                default: begin
                    if (clr_i) begin
                        done_q <= 1'b0;
                        ok_q   <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign empty_o = (state_q == SLOT_EMPTY);
    assign done_o  = done_q;
    assign ok_o    = ok_q;

    // R2: request to an empty mailbox makes it pending
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && empty_o) |=> !empty_o);

    // R3: completion of a pending mailbox frees it and flags it done
    p_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_i && !empty_o) |=> (empty_o && done_o && (ok_o == $past(fin_ok_i))));

    // R4: abort without completion frees the mailbox, success cleared
    p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !fin_i && !empty_o) |=> (empty_o && done_o && !ok_o));

    // R5: success flag never stands without the completion flag
    p_ok_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> done_o);

endmodule

// File: rtl/can_txmb_prio.sv
module can_txmb_prio #(
    parameter int NUM_MB = 3,
    parameter int KEY_W  = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_MB-1:0]         pend_i,
    input  logic [NUM_MB*KEY_W-1:0]   key_i,
    input  logic [NUM_MB-1:0]         force_clr_i,
    output logic [NUM_MB-1:0]         low_o,
    output logic [$clog2(NUM_MB)-1:0] code_o
);

    localparam int CODE_W = $clog2(NUM_MB);
    localparam int CNT_W  = $clog2(NUM_MB + 1);

    logic [KEY_W-1:0]  key_a [NUM_MB];
    logic [NUM_MB-1:0] low_d, low_q;
    logic [CODE_W-1:0] lo_idx, free_idx;
    logic [KEY_W-1:0]  lo_key;
    logic              lo_found, free_found;
    logic [CNT_W-1:0]  npend;

    for (genvar g = 0; g < NUM_MB; g++) begin : g_key
        assign key_a[g] = key_i[g*KEY_W +: KEY_W];
    end

    // scan: largest key among pending is lowest priority; ties go to higher index
    always_comb begin
        lo_found   = 1'b0;
        lo_idx     = '0;
        lo_key     = '0;
        free_found = 1'b0;
        free_idx   = '0;
        npend      = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (pend_i[i]) begin
                npend = npend + CNT_W'(1);
                if (!lo_found || key_a[i] >= lo_key) begin
                    lo_found = 1'b1;
                    lo_idx   = CODE_W'(i);
                    lo_key   = key_a[i];
                end
            end else if (!free_found) begin
                free_found = 1'b1;
                free_idx   = CODE_W'(i);
            end
        end
    end

    for (genvar g = 0; g < NUM_MB; g++) begin : g_low
        assign low_d[g] = (npend >= CNT_W'(2)) && lo_found &&
                          (lo_idx == CODE_W'(g)) && !force_clr_i[g];

        // R8: a request or clear strobe forces the flag low next cycle
        p_force_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
            force_clr_i[g] |=> !low_o[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_q <= '0;
        else        low_q <= low_d;
    end

    assign low_o  = low_q;
    assign code_o = free_found ? free_idx : lo_idx;

    // R7: at most one lowest-priority flag
    p_low_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(low_o));

    // R7: a flag needs at least two pending mailboxes in the cycle before
    p_low_multi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|low_o) |-> ($past($countones(pend_i)) >= 2));

    // R9: with a free mailbox the code names an empty one
    p_code_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&pend_i)) |-> !pend_i[code_o]);

    // R10: all busy, the code names the mailbox with the largest key
    p_code_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (&pend_i) |-> (key_a[code_o] == lo_key));

endmodule

// File: rtl/can_txmb_tracker.sv
module can_txmb_tracker
    import can_txmb_pkg::*;
#(
    parameter int NUM_MB = MB_COUNT,
    parameter int ID_W   = KEY_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_MB-1:0]         tx_req,
    input  logic [NUM_MB-1:0]         tx_abort,
    input  logic                      done_valid,
    input  logic [$clog2(NUM_MB)-1:0] done_idx,
    input  logic                      done_ok,
    input  logic [NUM_MB-1:0]         rqcp_clr,
    input  logic [NUM_MB*ID_W-1:0]    prio_key,
    output logic [NUM_MB-1:0]         mb_empty,
    output logic [NUM_MB-1:0]         req_done,
    output logic [NUM_MB-1:0]         tx_ok,
    output logic [NUM_MB-1:0]         low_flag,
    output logic [$clog2(NUM_MB)-1:0] mb_code,
    output logic [2*NUM_MB+$clog2(NUM_MB)-1:0] status_byte
);

    localparam int CODE_W = $clog2(NUM_MB);

    logic [NUM_MB-1:0] fin_vec;
    logic [NUM_MB-1:0] pend_vec;
    logic [NUM_MB-1:0] force_vec;

    for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
        assign fin_vec[g] = done_valid && (done_idx == CODE_W'(g));

        can_txmb_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (tx_req[g]),
            .abort_i  (tx_abort[g]),
            .fin_i    (fin_vec[g]),
            .fin_ok_i (done_ok),
            .clr_i    (rqcp_clr[g]),
            .empty_o  (mb_empty[g]),
            .done_o   (req_done[g]),
            .ok_o     (tx_ok[g])
        );
    end

    assign pend_vec  = ~mb_empty;
    assign force_vec = tx_req | rqcp_clr;

    can_txmb_prio #(
        .NUM_MB (NUM_MB),
        .KEY_W  (ID_W)
    ) u_prio (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_i      (pend_vec),
        .key_i       (prio_key),
        .force_clr_i (force_vec),
        .low_o       (low_flag),
        .code_o      (mb_code)
    );

    // R11: packed status byte
    assign status_byte = {low_flag, mb_empty, mb_code};

    // R3: completion for an empty mailbox leaves it empty
    p_idle_fin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && mb_empty[done_idx]) |=> mb_empty[$past(done_idx)]);

endmodule

// File: tb/can_txmb_tracker_tb_top.sv
`timescale 1ns/1ps
module can_txmb_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  tx_req, tx_abort, rqcp_clr;
    logic        done_valid, done_ok;
    logic [1:0]  done_idx;
    logic [32:0] prio_key;
    logic [2:0]  mb_empty, req_done, tx_ok, low_flag;
    logic [1:0]  mb_code;
    logic [7:0]  status_byte;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    can_txmb_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_abort(tx_abort),
        .done_valid(done_valid), .done_idx(done_idx), .done_ok(done_ok),
        .rqcp_clr(rqcp_clr), .prio_key(prio_key), .mb_empty(mb_empty),
        .req_done(req_done), .tx_ok(tx_ok), .low_flag(low_flag),
        .mb_code(mb_code), .status_byte(status_byte)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        tx_req = '0; tx_abort = '0; rqcp_clr = '0;
        done_valid = 1'b0; done_ok = 1'b0; done_idx = '0;
    endtask

    task automatic set_keys(input logic [10:0] k0, input logic [10:0] k1, input logic [10:0] k2);
        prio_key = {k2, k1, k0};
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic pulse_req(input logic [2:0] m);
        tx_req = m; step(); tx_req = '0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 empty", {5'd0, mb_empty}, 8'h07);
        chk("R1 done", {5'd0, req_done}, 8'h00);
        chk("R1 ok", {5'd0, tx_ok}, 8'h00);
        chk("R1 low", {5'd0, low_flag}, 8'h00);
        chk("R1 status", status_byte, 8'h1C);
    endtask

    task automatic t_request_priority();
        do_reset();
        set_keys(11'h100, 11'h200, 11'h050);
        pulse_req(3'b001);
        chk("R2 accept", {5'd0, mb_empty}, 8'h06);
        chk("R9 code next free", {6'd0, mb_code}, 8'h01);
        pulse_req(3'b001);
        chk("R2 req on pending", {5'd0, mb_empty}, 8'h06);
        chk("R7 single pending", {5'd0, low_flag}, 8'h00);
        pulse_req(3'b100);
        chk("R9 code", {6'd0, mb_code}, 8'h01);
        step();
        chk("R7 low mb0", {5'd0, low_flag}, 8'h01);
        pulse_req(3'b010);
        chk("R10 code all busy", {6'd0, mb_code}, 8'h01);
        step();
        chk("R11 status", status_byte, 8'h41);
        set_keys(11'h100, 11'h100, 11'h050);
        step();
        chk("R7 tie to higher index", {5'd0, low_flag}, 8'h02);
        set_keys(11'h100, 11'h100, 11'h300);
        #1;
        chk("R10 code follows key", {6'd0, mb_code}, 8'h02);
        step();
        chk("R7 low mb2", {5'd0, low_flag}, 8'h04);
    endtask

    task automatic t_complete_abort();
        do_reset();
        set_keys(11'h100, 11'h100, 11'h300);
        pulse_req(3'b111);
        done_valid = 1'b1; done_idx = 2'd2; done_ok = 1'b1;
        step(); idle_inputs();
        chk("R3 ok empty", {5'd0, mb_empty}, 8'h04);
        chk("R3 ok done", {5'd0, req_done}, 8'h04);
        chk("R3 ok flag", {5'd0, tx_ok}, 8'h04);
        chk("R9 only free", {6'd0, mb_code}, 8'h02);
        done_valid = 1'b1; done_idx = 2'd1; done_ok = 1'b0;
        step(); idle_inputs();
        chk("R3 fail done", {5'd0, req_done}, 8'h06);
        chk("R3 fail ok", {5'd0, tx_ok}, 8'h04);
        chk("R9 lowest free", {6'd0, mb_code}, 8'h01);
        done_valid = 1'b1; done_idx = 2'd1; done_ok = 1'b1;
        step(); idle_inputs();
        chk("R3 idle completion ignored", {2'd0, tx_ok, req_done}, 8'h26);
        tx_abort = 3'b001;
        step(); idle_inputs();
        chk("R4 abort empty", {5'd0, mb_empty}, 8'h07);
        chk("R4 abort flags", {2'd0, tx_ok, req_done}, 8'h27);
        tx_abort = 3'b001;
        step(); idle_inputs();
        chk("R4 abort on empty", {2'd0, mb_empty, req_done}, 8'h3F);
        chk("R4 abort on empty ok", {5'd0, tx_ok}, 8'h04);
    endtask

    task automatic t_collisions();
        do_reset();
        set_keys(11'h010, 11'h020, 11'h030);
        rqcp_clr = 3'b100;
        step(); idle_inputs();
        pulse_req(3'b001);
        done_valid = 1'b1; done_idx = 2'd0; done_ok = 1'b1; rqcp_clr = 3'b001;
        step(); idle_inputs();
        chk("R5 completion beats clear", {2'd0, tx_ok, req_done}, 8'h09);
        rqcp_clr = 3'b001;
        step(); idle_inputs();
        chk("R5 clear", {2'd0, tx_ok, req_done}, 8'h00);
        pulse_req(3'b001);
        tx_abort = 3'b001; done_valid = 1'b1; done_idx = 2'd0; done_ok = 1'b1;
        step(); idle_inputs();
        chk("R6 completion beats abort", {2'd0, tx_ok, req_done}, 8'h09);
        tx_req = 3'b010; tx_abort = 3'b010;
        step(); idle_inputs();
        chk("R6 request on empty with abort", {5'd0, mb_empty}, 8'h05);
    endtask

    task automatic t_low_force();
        do_reset();
        set_keys(11'h010, 11'h700, 11'h000);
        pulse_req(3'b011);
        step();
        chk("R7 settle", {5'd0, low_flag}, 8'h02);
        rqcp_clr = 3'b010;
        step(); idle_inputs();
        chk("R8 clear forces low", {5'd0, low_flag}, 8'h00);
        step();
        chk("R8 recovers", {5'd0, low_flag}, 8'h02);
        tx_req = 3'b010;
        step(); idle_inputs();
        chk("R8 request forces low", {5'd0, low_flag}, 8'h00);
        chk("R2 request on pending", {5'd0, mb_empty}, 8'h04);
        step();
        chk("R8 recovers again", {5'd0, low_flag}, 8'h02);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        rst_n = 1'b0;
        idle_inputs();
        set_keys('0, '0, '0);
        t_reset();
        t_request_priority();
        t_complete_abort();
        t_collisions();
        t_low_force();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule